// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block takes in 16-bit command words from a three-wire serial port. The three lines are an active-low frame select, a serial clock and a data line. A fast system clock samples all three inputs after a two-flop synchroniser on each. The control logic finds the falling edges of the serial clock and shifts one data bit in at each of them while the frame is held low. The most significant bit arrives first.

A frame is complete when exactly sixteen falling edges have been seen. The frame select then returns high, and at that point the finished word is placed on a parallel output with a single-cycle valid pulse. The receiver drops a frame that ends early without any sign of it. It also ignores every clock pulse that comes after the sixteenth, up to the end of the frame.

The receiver only delivers the word; a downstream block decodes it. The system clock must run at four or more times the serial clock rate so that every serial clock level lasts through the synchroniser.

Top module: `serial_word_rx`

## Requirements
- R1: While reset is asserted and right after it, `wordValid` is 0 and `wordOut` is all zeros.
- R2: While `frameN` is low, the bit on `sdata` is captured at each falling edge of `sclk`. The first captured bit becomes bit 15 of the word and the sixteenth becomes bit 0. The finished word appears on `wordOut`.
- R3: After a frame with sixteen falling edges, `wordValid` goes high for exactly one system-clock cycle once `frameN` rises. `wordOut` changes only together with that pulse and otherwise keeps its value.
- R4: A frame in which `frameN` rises after fewer than sixteen falling edges produces no pulse, and `wordOut` keeps the previous word.
- R5: Within one frame, falling edges after the sixteenth are ignored. The word delivered is made of the first sixteen bits, and the internal bit count never goes above sixteen.
- R6: Serial clock edges while `frameN` is high have no effect. Every frame starts again from an empty bit count.
- R7: Frames sent back to back, separated only by a short high period on `frameN`, each deliver their own word in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Frame select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock; data is captured on its falling edge |
| sdata | input | 1 | Serial data, MSB first |
| wordOut | output | 16 | Last completed word |
| wordValid | output | 1 | One-cycle pulse when wordOut takes a new word |

## Verification
Four patterns are used for the basic capture:
- An alternating, irregular word exposes bit-order or off-by-one shift errors.
- All-ones and all-zeros words show whether a bit gets stuck or the register fails to clear between frames.
- A word with only its end bits set checks that the first and the sixteenth edge both land in the right place.

Frames of fifteen bits and of twenty bits separate an abort from an overrun. Serial clock toggles during the idle period test that the counter only counts while the frame is active. Back-to-back frames check that the word from one frame cannot spill into the next.

// File: rtl/srx_pkg.sv
package srx_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic clear;  // frame inactive: empty the shift register
    logic shift;  // take one data bit
    logic load;   // hand the finished word to the output
  } srxStrobe_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= din[i];
        stage2 <= stage1;
      end
    end
    assign dout[i] = stage2;
  end

endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkS,
  input  logic             frameNS,
  output srxStrobe_t       strobe,
  output logic [CNT_W-1:0] bitCount
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic sclkD;
  logic frameND;
  logic sclkFall;
  logic frameRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD   <= 1'b0;
      frameND <= 1'b1;
    end else begin
      sclkD   <= sclkS;
      frameND <= frameNS;
    end
  end

  assign sclkFall  = sclkD & ~sclkS;
  assign frameRise = ~frameND & frameNS;

  always_comb begin
    strobe.clear = frameNS;
    strobe.shift = ~frameNS & sclkFall & (bitCount < FULL);
    strobe.load  = frameRise & (bitCount == FULL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bitCount <= '0;
    else if (strobe.clear) bitCount <= '0;
    else if (strobe.shift) bitCount <= bitCount + 1'b1;
  end

endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataS,
  input  srxStrobe_t        strobe,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);

  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobe.clear) shiftReg <= '0;
    else if (strobe.shift) shiftReg <= {shiftReg[WORD_W-2:0], dataS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strobe.load;
      if (strobe.load) wordOut <= shiftReg;
    end
  end

endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import srx_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic              sclk,
  input  logic              sdata,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);

  logic             frameNS;
  logic             sclkS;
  logic             dataS;
  logic [CNT_W-1:0] bitCount;
  srxStrobe_t       strobe;

  srx_sync #(.W(3), .RST_VAL(3'b100)) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din ({frameN, sclk, sdata}),
    .dout({frameNS, sclkS, dataS})
  );

  srx_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .sclkS   (sclkS),
    .frameNS (frameNS),
    .strobe  (strobe),
    .bitCount(bitCount)
  );

  srx_datapath #(.WORD_W(WORD_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .dataS    (dataS),
    .strobe   (strobe),
    .wordOut  (wordOut),
    .wordValid(wordValid)
  );

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameNS,
  input logic [CNT_W-1:0]  bitCount,
  input logic [WORD_W-1:0] wordOut,
  input logic              wordValid
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_W'(WORD_W)); // R5

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    frameNS |=> (bitCount == '0)); // R6

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordOut) |-> wordValid); // R3

  AST_FULL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> ($past(bitCount) == CNT_W'(WORD_W))); // R4

endmodule

bind serial_word_rx srx_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .frameNS  (frameNS),
  .bitCount (bitCount),
  .wordOut  (wordOut),
  .wordValid(wordValid)
);

// File: tb/serial_word_rx_tb_top.sv
`timescale 1ns/1ps
module serial_word_rx_tb_top;

  localparam int HALF = 4;  // system cycles per serial clock level

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdata = 1'b0;
  logic [15:0] wordOut;
  logic        wordValid;

  int checks = 0;
  int fails = 0;
  int validSeen = 0;
  int validExp = 0;
  bit done = 0;
  logic [15:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;  // 250 MHz

  serial_word_rx dut_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .sclk(sclk), .sdata(sdata),
    .wordOut(wordOut), .wordValid(wordValid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: sends the top n bits of pattern, MSB first, and records the expected word
  task automatic sendFrame(input logic [31:0] pattern, input int n, input string req);
    @(negedge clk);
    frameN = 1'b0;
    waitCyc(HALF);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      sdata = pattern[31-i];
      waitCyc(HALF);
      sclk = 1'b0;
      waitCyc(HALF);
    end
    if (n >= 16) begin
      expQ.push_back(pattern[31:16]);
      tagQ.push_back(req);
      validExp++;
    end
    frameN = 1'b1;
    waitCyc(HALF);
  endtask

  task automatic idleClocks(input int n, input logic bitVal);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; sdata = bitVal; waitCyc(HALF);
      sclk = 1'b0; waitCyc(HALF);
    end
  endtask

  // Monitor: compares each delivered word against the scoreboard
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && wordValid) begin
      validSeen++;
      check(!prevValid, "R3 pulse width", 32'(prevValid), 32'h0);
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected word", 32'(wordOut), 32'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(wordOut == e, t, 32'(wordOut), 32'(e));
      end
    end
    prevValid <= wordValid;
  end

  initial begin
    waitCyc(3);
    check(wordValid == 1'b0, "R1 valid in reset", 32'(wordValid), 32'h0);
    check(wordOut == 16'h0, "R1 word in reset", 32'(wordOut), 32'h0);
    rstN = 1'b1;
    waitCyc(4);
    check(wordValid == 1'b0, "R1 valid after reset", 32'(wordValid), 32'h0);
    check(wordOut == 16'h0, "R1 word after reset", 32'(wordOut), 32'h0);

    sendFrame(32'hA5C3_0000, 16, "R2 irregular word");
    sendFrame(32'hFFFF_0000, 16, "R2 all ones");
    sendFrame(32'h0000_0000, 16, "R2 all zeros");
    sendFrame(32'h8001_0000, 16, "R2 end bits");
    waitCyc(6);

    // R4: aborted frame of 15 bits leaves wordOut unchanged
    sendFrame(32'h7FFF_0000, 15, "R4");
    waitCyc(8);
    check(wordOut == 16'h8001, "R4 word kept after abort", 32'(wordOut), 32'h8001);
    check(validSeen == validExp, "R4 no pulse after abort", 32'(validSeen), 32'(validExp));

    // R5: twenty edges, only the first sixteen count
    sendFrame(32'h1234_F000, 20, "R5 surplus bits ignored");
    waitCyc(6);

    // R6: clocks while frame is high are ignored
    idleClocks(5, 1'b1);
    waitCyc(8);
    check(wordOut == 16'h1234, "R6 idle clocks no effect", 32'(wordOut), 32'h1234);
    sendFrame(32'h0F0F_0000, 16, "R6 fresh count after idle clocks");

    // R7: back to back frames
    sendFrame(32'hBEEF_0000, 16, "R7 first of pair");
    sendFrame(32'h4C21_0000, 16, "R7 second of pair");
    waitCyc(10);

    check(expQ.size() == 0, "R7 all words delivered", 32'(expQ.size()), 32'h0);
    check(validSeen == validExp, "R3 pulse count", 32'(validSeen), 32'(validExp));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule